// File: doc/BRIEF.md
# Full-Bridge Converter Real-Time Model (RK2 Sequencer)

This block is a fixed-point, real-time model of a full-bridge converter with conduction losses that drives an RC load with a series ESR. Each simulation step advances two state variables, inductor current and capacitor voltage, by a second-order Runge–Kutta (Heun) scheme. A single slope unit evaluates both derivatives. A five-phase sequencer shares it: an idle phase, then four working phases. The working phases prepare the source and load terms, take the first slope, take the second slope at the Euler-predicted point, and commit the new state.

The source voltage, the diode drop and the series resistance that the inductor sees depend on which of the four bridge switches are on. For the diode-conducting patterns they also depend on the direction of the inductor current. A combinational decoder turns the switch pattern and the current sign into three terms: a source voltage, a diode offset and a series resistance. Step size, component values and losses enter as fixed-point constants on input ports. The constants for the time step are pre-divided (dt/C and dt/L), so that each slope is already an increment.

A host strobes `start` once per model step and reads the state when `done` pulses. All values are signed two's complement with `FRAC` fractional bits. Multiplications truncate toward minus infinity.

Top module: `fb_rk2_model`

## Requirements
- R1: While reset is asserted, and after it is released, `il_out`, `vc_out` and `vo_out` are 0 and `done` is 0, and the sequencer is idle.
- R2: A `start` sampled high while idle begins a step. The step takes exactly four clock cycles. `done` is high for exactly one cycle, in the fifth cycle after the edge that sampled `start`. The sequencer is idle in that same cycle.
- R3: A `start` sampled high while a step is in progress has no effect: no second step runs and no extra `done` pulse appears.
- R4: `il_out` and `vc_out` change only at the edge that ends the fourth cycle of a step. During the step they hold their previous values.
- R5: With mul(a,b) = floor(a·b / 2^FRAC), the slopes are kc = mul(gc, i − mul(v, invr)) and kl = mul(gl, KR − KV1 − mul(KV2, i) − v). The first slope pair is taken at the stored state. The second is taken at (i + kl1, v + kc1). The new state is x + floor((k1 + k2)/2).
- R6: Each step loads `vo_out` with v + mul(resr, i − mul(v, invr)), using the state from before the step.
- R7: Switch pattern `sw_on` = 4'b0101 (switches 1 and 3 on; bit 0 is switch 1) gives KR = +vin, KV1 = 0, KV2 = 2·rds + rl. Pattern 4'b1010 gives KR = −vin with the same KV1 and KV2.
- R8: With all switches off, KV2 = 2·rd + rl. When the current is positive (il > 0), KR = −vin and KV1 = +2·vd. When il ≤ 0 (zero counts as non-positive), KR = +vin and KV1 = −2·vd.
- R9: With exactly one switch on, KV2 = rds + rd + rl. For switch 1 or 3 (bits 0, 2): KR = 0 and KV1 = +vd when il > 0; KR = +vin and KV1 = −vd otherwise. For switch 2 or 4 (bits 1, 3): KR = +vin and KV1 = +vd when il > 0; KR = 0 and KV1 = −vd otherwise.
- R10: Every other pattern, with two switches on in a leg or with three or four switches on, is decoded exactly as the all-off pattern of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one model step (honoured only when idle) |
| sw_on | input | 4 | Bridge switch states, bit k = switch k+1 on |
| p_vin | input | W | Input source voltage |
| p_vd | input | W | Diode forward drop |
| p_rds | input | W | Switch on-resistance |
| p_rd | input | W | Diode resistance |
| p_rl | input | W | Inductor winding resistance |
| p_invr | input | W | Reciprocal of load resistance |
| p_resr | input | W | Capacitor ESR |
| p_gc | input | W | dt/C step constant |
| p_gl | input | W | dt/L step constant |
| il_out | output | W | Inductor current state |
| vc_out | output | W | Capacitor voltage state |
| vo_out | output | W | Output voltage at the step's initial state |
| done | output | 1 | One-cycle pulse at the end of a step |

## Verification
On every cycle, the assertions check the phase order, the acceptance of `start` in idle and its rejection while busy, the single-cycle `done` pulse, and that the state and output registers hold outside their write phases. Only the directed scenarios can show the numbers: the Runge–Kutta arithmetic, the output voltage, and every branch of the loss decode. The decode cases include the zero-current case, both current signs for the diode and single-switch patterns, and the illegal patterns. The bench reaches these by steering the current positive and then negative with the diagonal patterns.

// File: rtl/fb_rk2_pkg.sv
package fb_rk2_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_MTERM  = 3'd1,
    PH_SLOPE1 = 3'd2,
    PH_SLOPE2 = 3'd3,
    PH_COMMIT = 3'd4
  } phase_e;

  typedef enum logic [2:0] {
    SW_DIAG_P,
    SW_DIAG_N,
    SW_ONE_HI,
    SW_ONE_LO,
    SW_FREE
  } swcls_e;

  function automatic swcls_e classify_sw(input logic [3:0] sw);
    swcls_e c;
    unique case (sw)
      4'b0101:          c = SW_DIAG_P;
      4'b1010:          c = SW_DIAG_N;
      4'b0001, 4'b0100: c = SW_ONE_HI;
      4'b0010, 4'b1000: c = SW_ONE_LO;
      default:          c = SW_FREE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/fb_loss_decode.sv
module fb_loss_decode
  import fb_rk2_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]          sw_on,
  input  logic                il_pos,
  input  logic signed [W-1:0] vin,
  input  logic signed [W-1:0] vd,
  input  logic signed [W-1:0] rds,
  input  logic signed [W-1:0] rd,
  input  logic signed [W-1:0] rl,
  output logic signed [W-1:0] kr,
  output logic signed [W-1:0] kv1,
  output logic signed [W-1:0] kv2
);

  swcls_e cls;
  logic signed [W-1:0] vd_pair;
  logic signed [W-1:0] r_switches;
  logic signed [W-1:0] r_diodes;
  logic signed [W-1:0] r_mixed;

  assign cls        = classify_sw(sw_on);
  assign vd_pair    = vd + vd;
  assign r_switches = rds + rds + rl;
  assign r_diodes   = rd + rd + rl;
  assign r_mixed    = rds + rd + rl;

  always_comb begin
    kr  = '0;
    kv1 = '0;
    kv2 = r_diodes;
    unique case (cls)
      SW_DIAG_P: begin
        kr  = vin;
        kv2 = r_switches;
      end
      SW_DIAG_N: begin
        kr  = -vin;
        kv2 = r_switches;
      end
      SW_ONE_HI: begin
        kv2 = r_mixed;
        kr  = il_pos ? '0 : vin;
        kv1 = il_pos ? vd : -vd;
      end
      SW_ONE_LO: begin
        kv2 = r_mixed;
        kr  = il_pos ? vin : '0;
        kv1 = il_pos ? vd : -vd;
      end
      default: begin
        kv2 = r_diodes;
        kr  = il_pos ? -vin : vin;
        kv1 = il_pos ? vd_pair : -vd_pair;
      end
    endcase
  end

endmodule

// File: rtl/fb_slope_unit.sv
module fb_slope_unit #(
  parameter int W    = 32,
  parameter int FRAC = 16
) (
  input  logic signed [W-1:0] x_il,
  input  logic signed [W-1:0] x_vc,
  input  logic signed [W-1:0] src_v,
  input  logic signed [W-1:0] ser_r,
  input  logic signed [W-1:0] invr,
  input  logic signed [W-1:0] gc,
  input  logic signed [W-1:0] gl,
  output logic signed [W-1:0] kc,
  output logic signed [W-1:0] kl
);

  localparam int PW = 2 * W;
  typedef logic signed [PW-1:0] wide_t;

  function automatic logic signed [W-1:0] mulq(input logic signed [W-1:0] a,
                                               input logic signed [W-1:0] b);
    wide_t p;
    p = wide_t'(a) * wide_t'(b);
    return W'(p >>> FRAC);
  endfunction

  logic signed [W-1:0] cap_i;
  logic signed [W-1:0] ind_v;

  assign cap_i = x_il - mulq(x_vc, invr);
  assign ind_v = src_v - mulq(ser_r, x_il) - x_vc;
  assign kc    = mulq(gc, cap_i);
  assign kl    = mulq(gl, ind_v);

endmodule

// File: rtl/fb_rk2_seq.sv
module fb_rk2_seq
  import fb_rk2_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_e phase,
  output logic   done
);

  phase_e phase_nx;

  always_comb begin
    unique case (phase)
      PH_IDLE:   phase_nx = start ? PH_MTERM : PH_IDLE;
      PH_MTERM:  phase_nx = PH_SLOPE1;
      PH_SLOPE1: phase_nx = PH_SLOPE2;
      PH_SLOPE2: phase_nx = PH_COMMIT;
      default:   phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      phase <= phase_nx;
      done  <= (phase == PH_COMMIT);
    end
  end

endmodule

// File: rtl/fb_rk2_model.sv
module fb_rk2_model
  import fb_rk2_pkg::*;
#(
  parameter int W    = 32,
  parameter int FRAC = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [3:0]          sw_on,
  input  logic signed [W-1:0] p_vin,
  input  logic signed [W-1:0] p_vd,
  input  logic signed [W-1:0] p_rds,
  input  logic signed [W-1:0] p_rd,
  input  logic signed [W-1:0] p_rl,
  input  logic signed [W-1:0] p_invr,
  input  logic signed [W-1:0] p_resr,
  input  logic signed [W-1:0] p_gc,
  input  logic signed [W-1:0] p_gl,
  output logic signed [W-1:0] il_out,
  output logic signed [W-1:0] vc_out,
  output logic signed [W-1:0] vo_out,
  output logic                done
);

  localparam int PW = 2 * W;
  typedef logic signed [PW-1:0] wide_t;
  typedef logic signed [W:0]    sum_t;

  function automatic logic signed [W-1:0] mulq(input logic signed [W-1:0] a,
                                               input logic signed [W-1:0] b);
    wide_t p;
    p = wide_t'(a) * wide_t'(b);
    return W'(p >>> FRAC);
  endfunction

  function automatic logic signed [W-1:0] heun_inc(input logic signed [W-1:0] a,
                                                   input logic signed [W-1:0] b);
    sum_t s;
    s = sum_t'(a) + sum_t'(b);
    return W'(s >>> 1);
  endfunction

  phase_e phase;
  logic   ph_idle, ph_mterm, ph_slope1, ph_slope2, ph_commit;

  fb_rk2_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .phase (phase),
    .done  (done)
  );

  assign ph_idle   = (phase == PH_IDLE);
  assign ph_mterm  = (phase == PH_MTERM);
  assign ph_slope1 = (phase == PH_SLOPE1);
  assign ph_slope2 = (phase == PH_SLOPE2);
  assign ph_commit = (phase == PH_COMMIT);

  logic signed [W-1:0] il_q, vc_q, vo_q;
  logic signed [W-1:0] src_q, ser_q, capi_q;
  logic signed [W-1:0] k1c_q, k1l_q, k2c_q, k2l_q;

  logic                il_pos;
  logic signed [W-1:0] dec_kr, dec_kv1, dec_kv2;

  assign il_pos = (il_q > 0);

  fb_loss_decode #(.W(W)) u_dec (
    .sw_on  (sw_on),
    .il_pos (il_pos),
    .vin    (p_vin),
    .vd     (p_vd),
    .rds    (p_rds),
    .rd     (p_rd),
    .rl     (p_rl),
    .kr     (dec_kr),
    .kv1    (dec_kv1),
    .kv2    (dec_kv2)
  );

  logic signed [W-1:0] eval_il, eval_vc, slope_c, slope_l;

  assign eval_il = ph_slope2 ? (il_q + k1l_q) : il_q;
  assign eval_vc = ph_slope2 ? (vc_q + k1c_q) : vc_q;

  fb_slope_unit #(.W(W), .FRAC(FRAC)) u_slope (
    .x_il  (eval_il),
    .x_vc  (eval_vc),
    .src_v (src_q),
    .ser_r (ser_q),
    .invr  (p_invr),
    .gc    (p_gc),
    .gl    (p_gl),
    .kc    (slope_c),
    .kl    (slope_l)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      ser_q  <= '0;
      capi_q <= '0;
    end else if (ph_mterm) begin
      src_q  <= dec_kr - dec_kv1;
      ser_q  <= dec_kv2;
      capi_q <= il_q - mulq(vc_q, p_invr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k1c_q <= '0;
      k1l_q <= '0;
      vo_q  <= '0;
    end else if (ph_slope1) begin
      k1c_q <= slope_c;
      k1l_q <= slope_l;
      vo_q  <= vc_q + mulq(p_resr, capi_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k2c_q <= '0;
      k2l_q <= '0;
    end else if (ph_slope2) begin
      k2c_q <= slope_c;
      k2l_q <= slope_l;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      il_q <= '0;
      vc_q <= '0;
    end else if (ph_commit) begin
      il_q <= il_q + heun_inc(k1l_q, k2l_q);
      vc_q <= vc_q + heun_inc(k1c_q, k2c_q);
    end
  end

  assign il_out = il_q;
  assign vc_out = vc_q;
  assign vo_out = vo_q;

endmodule

// File: rtl/fb_rk2_model_chk.sv
module fb_rk2_model_chk #(
  parameter int W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                done,
  input logic                ph_idle,
  input logic                ph_mterm,
  input logic                ph_slope1,
  input logic                ph_slope2,
  input logic                ph_commit,
  input logic signed [W-1:0] il_out,
  input logic signed [W-1:0] vc_out,
  input logic signed [W-1:0] vo_out
);

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) ph_idle && start |=> ph_mterm); // R2
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n) ph_idle && !start |=> ph_idle); // R2
  AST_MTERM_NEXT: assert property (@(posedge clk) disable iff (!rst_n) ph_mterm |=> ph_slope1); // R2
  AST_SLOPE1_NEXT: assert property (@(posedge clk) disable iff (!rst_n) ph_slope1 |=> ph_slope2); // R2
  AST_SLOPE2_NEXT: assert property (@(posedge clk) disable iff (!rst_n) ph_slope2 |=> ph_commit); // R2
  AST_COMMIT_DONE: assert property (@(posedge clk) disable iff (!rst_n) ph_commit |=> done && ph_idle); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (ph_slope1 || ph_slope2 || ph_commit) |=> !ph_mterm); // R3
  AST_STATE_HELD: assert property (@(posedge clk) disable iff (!rst_n) !ph_commit |=> $stable(il_out) && $stable(vc_out)); // R4
  AST_VO_HELD: assert property (@(posedge clk) disable iff (!rst_n) !ph_slope1 |=> $stable(vo_out)); // R6

endmodule

bind fb_rk2_model fb_rk2_model_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .ph_idle   (ph_idle),
  .ph_mterm  (ph_mterm),
  .ph_slope1 (ph_slope1),
  .ph_slope2 (ph_slope2),
  .ph_commit (ph_commit),
  .il_out    (il_out),
  .vc_out    (vc_out),
  .vo_out    (vo_out)
);

// File: tb/fb_rk2_model_tb.sv
module fb_rk2_model_tb;

  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] sw_on = 4'b0000;
  logic signed [W-1:0] p_vin, p_vd, p_rds, p_rd, p_rl, p_invr, p_resr, p_gc, p_gl;
  logic signed [W-1:0] il_out, vc_out, vo_out;
  logic done;

  always #2 clk = ~clk;

  fb_rk2_model u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sw_on(sw_on),
    .p_vin(p_vin), .p_vd(p_vd), .p_rds(p_rds), .p_rd(p_rd), .p_rl(p_rl),
    .p_invr(p_invr), .p_resr(p_resr), .p_gc(p_gc), .p_gl(p_gl),
    .il_out(il_out), .vc_out(vc_out), .vo_out(vo_out), .done(done)
  );

  int n_run = 0;
  int n_fail = 0;
  int m_il = 0;
  int m_vc = 0;
  int e_vo = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mq(input int a, input int b);
    longint p;
    p = longint'(a) * longint'(b);
    return int'(p >>> 16);
  endfunction

  function automatic int half_sum(input int a, input int b);
    return int'((longint'(a) + longint'(b)) >>> 1);
  endfunction

  // Loss terms from switch pattern and current sign (R7, R8, R9, R10)
  task automatic lut(input logic [3:0] s, input int il, output int kr, output int kv1, output int kv2);
    bit pos;
    pos = (il > 0);
    if (s == 4'b0101) begin
      kr = p_vin; kv1 = 0; kv2 = 2 * p_rds + p_rl;
    end else if (s == 4'b1010) begin
      kr = -p_vin; kv1 = 0; kv2 = 2 * p_rds + p_rl;
    end else if ($countones(s) == 1) begin
      kv2 = p_rds + p_rd + p_rl;
      kv1 = pos ? p_vd : -p_vd;
      if (s[0] || s[2]) kr = pos ? 0 : p_vin;
      else              kr = pos ? p_vin : 0;
    end else begin
      kv2 = 2 * p_rd + p_rl;
      kr  = pos ? -p_vin : p_vin;
      kv1 = pos ? 2 * p_vd : -2 * p_vd;
    end
  endtask

  // Heun step of the reference model (R5, R6)
  task automatic model_step(input logic [3:0] s);
    int kr, kv1, kv2, src, c1, l1, c2, l2, pi, pv;
    lut(s, m_il, kr, kv1, kv2);
    src  = kr - kv1;
    e_vo = m_vc + mq(p_resr, m_il - mq(m_vc, p_invr));
    c1 = mq(p_gc, m_il - mq(m_vc, p_invr));
    l1 = mq(p_gl, src - mq(kv2, m_il) - m_vc);
    pi = m_il + l1;
    pv = m_vc + c1;
    c2 = mq(p_gc, pi - mq(pv, p_invr));
    l2 = mq(p_gl, src - mq(kv2, pi) - pv);
    m_il = m_il + half_sum(l1, l2);
    m_vc = m_vc + half_sum(c1, c2);
  endtask

  task automatic run_step(input logic [3:0] s, input bit poke, input string req);
    int pre_il, pre_vc;
    pre_il = m_il;
    pre_vc = m_vc;
    @(negedge clk);
    sw_on = s;
    start = 1'b1;
    model_step(s);
    for (int c = 1; c <= 5; c++) begin
      @(negedge clk);
      start = poke && (c == 2 || c == 4);
      if (c < 5) begin
        if (il_out !== pre_il || vc_out !== pre_vc || done !== 1'b0)
          chk("R4", "state held mid-step", il_out, pre_il);
        else
          n_run++;
      end else begin
        chk("R2", "done in fifth cycle", int'(done), 1);
      end
    end
    chk(req, "il after step", il_out, m_il);
    chk(req, "vc after step", vc_out, m_vc);
    chk("R6", "vo from pre-step state", vo_out, e_vo);
    @(negedge clk);
    chk("R2", "done one cycle wide", int'(done), 0);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (done !== 1'b0 || il_out !== m_il) chk("R3", "no extra step", il_out, m_il);
    end
  endtask

  task automatic t_reset;
    chk("R1", "il reset", il_out, 0);
    chk("R1", "vc reset", vc_out, 0);
    chk("R1", "vo reset", vo_out, 0);
    chk("R1", "done reset", int'(done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "idle after release", int'(done), 0);
    chk("R1", "il after release", il_out, 0);
  endtask

  task automatic t_zero_current;  // R8: il == 0 takes the non-positive branch
    run_step(4'b0000, 1'b0, "R8");
  endtask

  task automatic t_diag_pos;      // R7, R5
    for (int i = 0; i < 4; i++) run_step(4'b0101, 1'b0, "R7");
    chk("R7", "current driven positive", int'(m_il > 0), 1);
  endtask

  task automatic t_single_pos;    // R9 with il > 0
    run_step(4'b0001, 1'b0, "R9");
    run_step(4'b0100, 1'b0, "R9");
    run_step(4'b0010, 1'b0, "R9");
    run_step(4'b1000, 1'b0, "R9");
  endtask

  task automatic t_freewheel_pos; // R8 with il > 0
    run_step(4'b0101, 1'b0, "R5");
    run_step(4'b0000, 1'b0, "R8");
  endtask

  task automatic t_diag_neg;      // R7 opposite diagonal
    for (int i = 0; i < 10; i++) run_step(4'b1010, 1'b0, "R7");
    chk("R7", "current driven negative", int'(m_il < 0), 1);
  endtask

  task automatic t_neg_branches;  // R8, R9 with il <= 0
    run_step(4'b0000, 1'b0, "R8");
    run_step(4'b1010, 1'b0, "R5");
    run_step(4'b0100, 1'b0, "R9");
    run_step(4'b1010, 1'b0, "R5");
    run_step(4'b1000, 1'b0, "R9");
  endtask

  task automatic t_illegal;       // R10
    run_step(4'b0011, 1'b0, "R10");
    run_step(4'b1111, 1'b0, "R10");
    run_step(4'b1101, 1'b0, "R10");
  endtask

  task automatic t_busy_start;    // R3
    run_step(4'b0101, 1'b1, "R3");
    run_step(4'b1010, 1'b1, "R3");
  endtask

  initial begin
    p_vin  = 200 * 65536;
    p_vd   = 45875;
    p_rds  = 6554;
    p_rd   = 52429;
    p_rl   = 328;
    p_invr = 328;
    p_resr = 23593;
    p_gc   = 3277;
    p_gl   = 1311;
    #1;
    t_reset();
    t_zero_current();
    t_diag_pos();
    t_single_pos();
    t_freewheel_pos();
    t_diag_neg();
    t_neg_branches();
    t_illegal();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule